// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This block is one programmable logic cell for a reconfigurable fabric. Two 4-input lookup tables (the F table and the G table) each evaluate any Boolean function of their own four inputs. Their two results, together with one extra direct input, address an 8-entry third table (the H table). A function of up to nine inputs can therefore be built inside a single cell. Next to the tables, a dedicated full-adder path produces a sum bit and a carry out. The carry out goes straight to the neighbouring cell and never passes through a table.

Every table bit and every mode choice sits in a single serial chain of configuration flip-flops. The chain is loaded one bit per clock while `cfg_en` is high. After loading, either primary table can be turned into a 16x1 RAM. Its own four inputs then form the address, a write strobe stores a data bit on the clock edge, and the table output gives an asynchronous read. Each of the two outputs can come straight from the combinational path or from an output flip-flop.

Top module: `lut_cascade_cell`

## Requirements
- R1: When configured with y_sum=0 and reg_y=0, `y_out` equals F-table bit `cfg[f_in]`, for every F-table content and every `f_in`.
- R2: When configured with reg_x=0, `x_out` equals H-table bit `cfg[32 + {h_in, g, f}]`. Here f = `cfg[f_in]`, g = `cfg[16 + g_in]`, and f is the least significant bit of the H index.
- R3: `cout` is the majority of `f_in[0]`, `g_in[0]` and `cin` at all times, whatever the configuration. With y_sum=1 and reg_y=0, `y_out` equals `f_in[0] ^ g_in[0] ^ cin`.
- R4: With reg_x=1 or reg_y=1, the chosen output shows the value its combinational path had at the last rising clock edge. It holds that value while the inputs change between edges.
- R5: While `cfg_en` is high, each rising edge shifts `cfg_in` into the chain's top bit (bit 44) and moves every bit down one place. After 45 shifts, the first bit sent sits at bit 0. The fields are: F table in bits 15:0, G table in bits 31:16, H table in bits 39:32, reg_x in bit 40, reg_y in bit 41, y_sum in bit 42, ram_f in bit 43 and ram_g in bit 44.
- R6: `x_out` and `y_out` are 0 until 45 bits have been shifted in since reset. They are also 0 in any cycle in which `cfg_en` is high.
- R7: With ram_f=1, a rising edge with `wr_en` high stores `wr_data` into F-table entry `f_in`. The new value appears on the F output (visible at `y_out` in plain mode) with no further clock.
- R8: With ram_g=1, a rising edge with `wr_en` high stores `wr_data` into G-table entry `g_in`.
- R9: A write strobe leaves a table unchanged when that table's RAM bit is 0.
- R10: A write strobe is ignored in any cycle in which `cfg_en` is high. That cycle performs only the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the chain and the output flops |
| cfg_en | input | 1 | Shift the configuration chain by one bit this cycle |
| cfg_in | input | 1 | Serial configuration data |
| f_in | input | 4 | F-table inputs; RAM address in F memory mode; bit 0 is adder operand A |
| g_in | input | 4 | G-table inputs; RAM address in G memory mode; bit 0 is adder operand B |
| h_in | input | 1 | Direct input, most significant H-table index bit |
| cin | input | 1 | Carry from the previous cell |
| wr_en | input | 1 | Memory-mode write strobe |
| wr_data | input | 1 | Memory-mode write data |
| x_out | output | 1 | H-table output, direct or registered |
| y_out | output | 1 | F-table output or sum bit, direct or registered |
| cout | output | 1 | Carry to the next cell |

## Verification
The bench builds the cell with its default 4-input primary tables, so the chain is 45 bits long. That keeps the full input space at ten bits (two table address nibbles, the direct input and carry in), and each random configuration is swept over all 1024 combinations against a model computed in the bench. With this size, every RAM address can be written and read back in both memory modes. The bench also covers two edge cases: a chain one bit short of full, and a write that collides with a shift.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    // The third table always takes two primary outputs plus one direct input.
    localparam int CAS_IN    = 3;
    localparam int MODE_BITS = 5;

    // Top of the configuration chain; first member is the most significant bit.
    typedef struct packed {
        logic ram_g;
        logic ram_f;
        logic y_sum;
        logic reg_y;
        logic reg_x;
    } cell_mode_t;
endpackage

// File: rtl/lcc_lut.sv
module lcc_lut #(
    parameter int IN = 4
) (
    input  logic [(1<<IN)-1:0] table_i,
    input  logic [IN-1:0]      sel_i,
    output logic               out_o
);
    assign out_o = table_i[sel_i];
endmodule

// File: rtl/lcc_carry.sv
module lcc_carry (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic sum_o,
    output logic carry_o
);
    assign sum_o   = a_i ^ b_i ^ c_i;
    assign carry_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/lcc_cfg_chain.sv
module lcc_cfg_chain
    import lcc_pkg::*;
#(
    parameter int LUT_IN = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_en,
    input  logic                           cfg_in,
    input  logic                           wr_en,
    input  logic                           wr_data,
    input  logic [LUT_IN-1:0]              addr_f,
    input  logic [LUT_IN-1:0]              addr_g,
    output logic [(1<<LUT_IN)-1:0]         tbl_f_o,
    output logic [(1<<LUT_IN)-1:0]         tbl_g_o,
    output logic [(1<<CAS_IN)-1:0]         tbl_h_o,
    output cell_mode_t                     mode_o,
    output logic                           ready_o
);
    localparam int LUT_BITS = 1 << LUT_IN;
    localparam int CAS_BITS = 1 << CAS_IN;
    localparam int CFG_BITS = 2*LUT_BITS + CAS_BITS + MODE_BITS;
    localparam int CNT_W    = $clog2(CFG_BITS + 1);

    typedef struct packed {
        logic [CFG_BITS-1:0] cfg;
        logic [CNT_W-1:0]    cnt;
    } chain_t;

    chain_t st_d, st_q;
    logic   loaded;

    assign loaded  = (st_q.cnt == CNT_W'(CFG_BITS));
    assign mode_o  = cell_mode_t'(st_q.cfg[CFG_BITS-1 -: MODE_BITS]);
    assign tbl_f_o = st_q.cfg[LUT_BITS-1:0];
    assign tbl_g_o = st_q.cfg[2*LUT_BITS-1:LUT_BITS];
    assign tbl_h_o = st_q.cfg[2*LUT_BITS+CAS_BITS-1:2*LUT_BITS];
    assign ready_o = loaded && !cfg_en;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.cfg = {cfg_in, st_q.cfg[CFG_BITS-1:1]};
            if (!loaded) st_d.cnt = st_q.cnt + 1'b1;
        end else if (wr_en && loaded) begin
            if (mode_o.ram_f) st_d.cfg[int'(addr_f)] = wr_data;
            if (mode_o.ram_g) st_d.cfg[LUT_BITS + int'(addr_g)] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (st_q.cfg[CFG_BITS-1] == $past(cfg_in)));                 // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !wr_en) |=> $stable(st_q.cfg));                          // R5
    AST_RAM_F_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ready_o && mode_o.ram_f) |=> (tbl_f_o[$past(addr_f)] == $past(wr_data))); // R7
    AST_RAM_G_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ready_o && mode_o.ram_g) |=> (tbl_g_o[$past(addr_g)] == $past(wr_data))); // R8
    AST_ROM_F_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_en && !mode_o.ram_f) |=> $stable(tbl_f_o));            // R9
    AST_SHIFT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && wr_en) |=> (tbl_f_o[LUT_BITS-2:0] == $past(st_q.cfg[LUT_BITS-1:1]))); // R10
endmodule

// File: rtl/lut_cascade_cell.sv
module lut_cascade_cell
    import lcc_pkg::*;
#(
    parameter int LUT_IN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_in,
    input  logic [LUT_IN-1:0] f_in,
    input  logic [LUT_IN-1:0] g_in,
    input  logic              h_in,
    input  logic              cin,
    input  logic              wr_en,
    input  logic              wr_data,
    output logic              x_out,
    output logic              y_out,
    output logic              cout
);
    localparam int LUT_BITS = 1 << LUT_IN;
    localparam int CAS_BITS = 1 << CAS_IN;
    localparam int N_PRIM   = 2;

    logic [LUT_BITS-1:0] prim_tbl [N_PRIM];
    logic [LUT_IN-1:0]   prim_sel [N_PRIM];
    logic                prim_o   [N_PRIM];
    logic [CAS_BITS-1:0] h_tbl;
    logic                h_o;
    logic                sum_o;
    logic                ready;
    cell_mode_t          mode;

    typedef struct packed {
        logic x;
        logic y;
    } out_ff_t;

    out_ff_t ff_d, ff_q;

    lcc_cfg_chain #(.LUT_IN(LUT_IN)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .addr_f  (f_in),
        .addr_g  (g_in),
        .tbl_f_o (prim_tbl[0]),
        .tbl_g_o (prim_tbl[1]),
        .tbl_h_o (h_tbl),
        .mode_o  (mode),
        .ready_o (ready)
    );

    always_comb begin
        prim_sel[0] = f_in;
        prim_sel[1] = g_in;
    end

    for (genvar i = 0; i < N_PRIM; i++) begin : g_prim
        lcc_lut #(.IN(LUT_IN)) u_lut (
            .table_i (prim_tbl[i]),
            .sel_i   (prim_sel[i]),
            .out_o   (prim_o[i])
        );
    end

    lcc_lut #(.IN(CAS_IN)) u_h_lut (
        .table_i (h_tbl),
        .sel_i   ({h_in, prim_o[1], prim_o[0]}),
        .out_o   (h_o)
    );

    lcc_carry u_carry (
        .a_i     (f_in[0]),
        .b_i     (g_in[0]),
        .c_i     (cin),
        .sum_o   (sum_o),
        .carry_o (cout)
    );

    always_comb begin
        ff_d.x = h_o;
        ff_d.y = mode.y_sum ? sum_o : prim_o[0];
    end

    always_ff @(posedge clk) begin
        if (rst) ff_q <= '0;
        else     ff_q <= ff_d;
    end

    assign x_out = ready & (mode.reg_x ? ff_q.x : h_o);
    assign y_out = ready & (mode.reg_y ? ff_q.y : ff_d.y);

    AST_CARRY_MAJORITY: assert property (@(posedge clk) disable iff (rst)
        cout == ($countones({f_in[0], g_in[0], cin}) >= 2));                 // R3
    AST_REG_X_DELAY: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready) && mode.reg_x && $stable(mode)) |-> (x_out == $past(h_o))); // R4
    AST_GATED_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (!x_out && !y_out));                                      // R6
endmodule

// File: tb/lut_cascade_cell_tb.sv
module lut_cascade_cell_tb;
    localparam int LB = 16;
    localparam int CB = 45;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, cfg_en, cfg_in, h_in, cin, wr_en, wr_data;
    logic [3:0] f_in, g_in;
    logic       x_out, y_out, cout;

    lut_cascade_cell u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .f_in(f_in), .g_in(g_in), .h_in(h_in), .cin(cin),
        .wr_en(wr_en), .wr_data(wr_data),
        .x_out(x_out), .y_out(y_out), .cout(cout)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [CB-1:0] m;

    function automatic logic [CB-1:0] mk(logic [15:0] f, logic [15:0] g, logic [7:0] h, logic [4:0] md);
        return {md, h, g, f};
    endfunction

    function automatic logic ex_x(logic [3:0] fi, logic [3:0] gi, logic hi);
        logic fo, go;
        fo = m[fi];
        go = m[LB + int'(gi)];
        return m[2*LB + int'({hi, go, fo})];
    endfunction

    function automatic logic ex_y(logic [3:0] fi, logic [3:0] gi, logic ci);
        return m[42] ? (fi[0] ^ gi[0] ^ ci) : m[fi];
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(int c);
        f_in = c[3:0]; g_in = c[7:4]; h_in = c[8]; cin = c[9];
    endtask

    task automatic load(logic [CB-1:0] v);
        for (int i = 0; i < CB; i++) begin
            @(negedge clk); cfg_en = 1'b1; cfg_in = v[i];
        end
        @(negedge clk); cfg_en = 1'b0;
        m = v;
    endtask

    task automatic sweep(string tag);
        for (int c = 0; c < 1024; c++) begin
            @(negedge clk); drive(c); #1;
            chk({tag, " R2 x"}, x_out, ex_x(f_in, g_in, h_in));
            chk({tag, m[42] ? " R3 sum" : " R1 y"}, y_out, ex_y(f_in, g_in, cin));
            chk({tag, " R3 cout"}, cout, (f_in[0] & g_in[0]) | (f_in[0] & cin) | (g_in[0] & cin));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_en = 0; cfg_in = 0; wr_en = 0; wr_data = 0; drive(10'h3ff);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R6 reset x", x_out, 1'b0);
        chk("R6 reset y", y_out, 1'b0);
    endtask

    task automatic t_partial();
        for (int i = 0; i < CB-1; i++) begin
            @(negedge clk); cfg_en = 1'b1; cfg_in = 1'b1;
        end
        @(negedge clk); cfg_en = 1'b0; drive(10'h001);
        @(negedge clk); #1;
        chk("R6 short chain x", x_out, 1'b0);
        chk("R6 short chain y", y_out, 1'b0);
        cfg_en = 1'b1; cfg_in = 1'b1;
        @(posedge clk); #1;
        chk("R6 shifting x", x_out, 1'b0);
        chk("R6 shifting y", y_out, 1'b0);
        @(negedge clk); cfg_en = 1'b0; #1;
        m = '1;
        chk("R6 released x", x_out, 1'b1);
        chk("R6 released y sum", y_out, 1'b1);
    endtask

    task automatic t_comb();
        load(mk(16'(($urandom)), 16'(($urandom)), 8'(($urandom)), 5'b00000));
        sweep("cfgA");
        load(mk(16'h6996, 16'hA5C3, 8'b1110_1000, 5'b00000));
        sweep("cfgB");
        load(mk(16'(($urandom)), 16'(($urandom)), 8'(($urandom)), 5'b00100));
        sweep("cfgC");
    endtask

    task automatic t_registered();
        logic ex, ey, hx, hy;
        load(mk(16'(($urandom)), 16'(($urandom)), 8'(($urandom)), 5'b00011));
        for (int k = 0; k < 24; k++) begin
            int c;
            c = int'($urandom) & 10'h3ff;
            @(negedge clk); drive(c);
            ex = ex_x(f_in, g_in, h_in); ey = ex_y(f_in, g_in, cin);
            @(posedge clk); #1;
            chk("R4 reg x", x_out, ex);
            chk("R4 reg y", y_out, ey);
            hx = x_out; hy = y_out;
            @(negedge clk); drive(c ^ 10'h3ff); #1;
            chk("R4 hold x", x_out, hx);
            chk("R4 hold y", y_out, hy);
        end
    endtask

    task automatic t_ram_f();
        load(mk(16'(($urandom)), 16'h0000, 8'hF0, 5'b01000));
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); f_in = 4'(a); wr_en = 1'b1; wr_data = ~m[a];
            m[a] = ~m[a];
            @(negedge clk); wr_en = 1'b0; #1;
            chk("R7 async read after write", y_out, m[a]);
        end
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); f_in = 4'(a); #1;
            chk("R7 readback", y_out, m[a]);
        end
    endtask

    task automatic t_ram_g();
        load(mk(16'h0000, 16'(($urandom)), 8'b1100_1100, 5'b10000));
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); g_in = 4'(a); wr_en = 1'b1; wr_data = a[0] ^ a[2];
            m[LB + a] = a[0] ^ a[2];
            @(negedge clk); wr_en = 1'b0;
        end
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); g_in = 4'(a); f_in = 4'(a); h_in = a[1]; #1;
            chk("R8 G ram readback via x", x_out, m[LB + a]);
        end
    endtask

    task automatic t_rom_ignore();
        load(mk(16'(($urandom)), 16'(($urandom)), 8'b1100_1100, 5'b00000));
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); f_in = 4'(a); g_in = 4'(a); wr_en = 1'b1; wr_data = ~m[a];
        end
        @(negedge clk); wr_en = 1'b0;
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); f_in = 4'(a); g_in = 4'(a); h_in = 1'b0; #1;
            chk("R9 F unchanged", y_out, m[a]);
            chk("R9 G unchanged", x_out, m[LB + a]);
        end
    endtask

    task automatic t_cfg_priority();
        logic [CB-1:0] v;
        v = mk(16'(($urandom)), 16'(($urandom)), 8'b1010_1010, 5'b01000);
        load(v);
        @(negedge clk);
        f_in = 4'd5; cfg_en = 1'b1; cfg_in = 1'b0; wr_en = 1'b1;
        m = {1'b0, v[CB-1:1]};
        wr_data = ~m[5];
        @(negedge clk); cfg_en = 1'b0; wr_en = 1'b0;
        for (int a = 0; a < LB; a++) begin
            @(negedge clk); f_in = 4'(a); g_in = 4'd0; h_in = 1'b0; #1;
            chk("R10 shift wins over write", x_out, ex_x(f_in, g_in, h_in));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(7));
        t_reset();
        t_partial();
        t_comb();
        t_registered();
        t_ram_f();
        t_ram_g();
        t_rom_ignore();
        t_cfg_priority();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule